// File: doc/BRIEF.md
# Split-Carry Next-PC Incrementer

This block produces the sequential successor of a 32-bit fetch address in a
machine whose instructions are 1, 2, 5 or 6 bytes long. Two decode flags give
the length: one says an operand-register byte follows the opcode, and the
other says a four-byte constant word follows. The incrementer does not wait
for the length before it does the wide part of the sum. The upper field of the
address (everything above the three least significant bits) is incremented
speculatively as soon as the address is known. A three-bit adder adds the
length to the low field, and its carry-out then picks either the raw or the
pre-incremented upper field. Only a small adder and one multiplexer level
therefore sit behind the late-arriving decode flags.

The datapath is combinational. A parameter adds an output register so that
the block can sit at a pipeline boundary or be tested on a clock. Field
widths, byte counts and the incrementer structure are parameters. Illegal
combinations are rejected at elaboration.

Top module: `fetch_pc_incr`

## Requirements
- R1: `ilen_o` equals 1 plus 1 when `need_regid_i` is high plus 4 when `need_const_i` is high. The only values are therefore 1, 2, 5 and 6. It is combinational in the current inputs.
- R2: The next address equals `pc_i` plus the length, taken modulo 2^32, for every address and flag combination.
- R3: Bits [2:0] of the next address equal `pc_i[2:0]` plus the length, modulo 8.
- R4: When `pc_i[2:0]` plus the length is below 8, bits [31:3] of the next address equal `pc_i[31:3]` unchanged.
- R5: When `pc_i[2:0]` plus the length is 8 or more, bits [31:3] of the next address equal `pc_i[31:3]` plus one.
- R6: When `pc_i[31:3]` is all ones and the low sum carries, the upper field wraps to zero. No error or extra bit is produced.
- R7: With the default `REG_OUT = 1`, `next_pc_o` shows the result for the inputs present at a rising clock edge after that edge, which is one cycle of latency. While `rst_n` is low, `next_pc_o` is zero. `rst_n` is an asynchronous, active-low reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| pc_i | input | 32 | Currently selected fetch address |
| need_regid_i | input | 1 | Instruction carries an operand-register byte |
| need_const_i | input | 1 | Instruction carries a four-byte constant word |
| ilen_o | output | 3 | Decoded instruction length in bytes |
| next_pc_o | output | 32 | Sequential next fetch address |

## Verification
A wrong carry from the low adder, or a wrong choice in the upper-field select, shows up at the ports as an address that is exactly 8 bytes too high or too low. That error appears only on vectors whose low three bits plus the length cross a multiple of eight. For this reason the stimulus sweeps every low-field value against every length, instead of relying on random addresses alone. A fault in the speculative incrementer appears only on the carrying vectors, and it is most visible when a long run of trailing ones must ripple, up to the all-ones wrap. With the output register present, every such fault is visible on the cycle right after the inputs are applied, because no other state is involved.

// File: rtl/fetch_pc_incr_pkg.sv
package fetch_pc_incr_pkg;

   typedef enum logic [0:0] {
      INC_BEHAV  = 1'b0,
      INC_PREFIX = 1'b1
   } inc_style_e;

   function automatic int unsigned max_len(input int unsigned base_b,
                                           input int unsigned reg_b,
                                           input int unsigned const_b);
      return base_b + reg_b + const_b;
   endfunction

   function automatic int unsigned bits_for(input int unsigned value);
      int unsigned n;
      n = 1;
      while ((1 << n) <= value) n++;
      return n;
   endfunction

endpackage

// File: rtl/fetch_pc_incr_len.sv
module fetch_pc_incr_len #(
   parameter int unsigned LEN_W       = 3,
   parameter int unsigned BASE_BYTES  = 1,
   parameter int unsigned REGID_BYTES = 1,
   parameter int unsigned CONST_BYTES = 4
) (
   input  logic             has_regid,
   input  logic             has_const,
   output logic [LEN_W-1:0] len
);
   import fetch_pc_incr_pkg::*;

   localparam int unsigned LMAX = max_len(BASE_BYTES, REGID_BYTES, CONST_BYTES);
   localparam logic [LEN_W-1:0] BASE_V  = LEN_W'(BASE_BYTES);
   localparam logic [LEN_W-1:0] REGID_V = LEN_W'(REGID_BYTES);
   localparam logic [LEN_W-1:0] CONST_V = LEN_W'(CONST_BYTES);

   if (LMAX >= (1 << LEN_W)) begin : g_len_too_wide
      $error("fetch_pc_incr_len: longest instruction does not fit LEN_W");
   end

   logic [LEN_W-1:0] reg_part;
   logic [LEN_W-1:0] const_part;

   always_comb begin
      reg_part   = has_regid ? REGID_V : '0;
      const_part = has_const ? CONST_V : '0;
      len        = BASE_V + reg_part + const_part;
   end

endmodule

// File: rtl/fetch_pc_incr_hi.sv
module fetch_pc_incr_hi #(
   parameter int unsigned HI_W  = 29,
   parameter fetch_pc_incr_pkg::inc_style_e STYLE = fetch_pc_incr_pkg::INC_PREFIX
) (
   input  logic [HI_W-1:0] hi_raw,
   output logic [HI_W-1:0] hi_inc
);
   import fetch_pc_incr_pkg::*;

   if (HI_W < 1) begin : g_bad_width
      $error("fetch_pc_incr_hi: HI_W must be at least 1");
   end

   if (STYLE == INC_BEHAV) begin : g_behav
      always_comb hi_inc = hi_raw + HI_W'(1);
   end else begin : g_prefix
      logic [HI_W:0] run;
      assign run[0] = 1'b1;
      for (genvar i = 0; i < HI_W; i++) begin : g_bit
         assign run[i+1]  = run[i] & hi_raw[i];
         assign hi_inc[i] = hi_raw[i] ^ run[i];
      end
   end

endmodule

// File: rtl/fetch_pc_incr_lo.sv
module fetch_pc_incr_lo #(
   parameter int unsigned LO_W = 3
) (
   input  logic [LO_W-1:0] lo_raw,
   input  logic [LO_W-1:0] len,
   output logic [LO_W-1:0] lo_sum,
   output logic            carry
);
   logic [LO_W:0] wide;

   always_comb begin
      wide   = {1'b0, lo_raw} + {1'b0, len};
      lo_sum = wide[LO_W-1:0];
      carry  = wide[LO_W];
   end

endmodule

// File: rtl/fetch_pc_incr_sel.sv
module fetch_pc_incr_sel #(
   parameter int unsigned HI_W = 29
) (
   input  logic            carry,
   input  logic [HI_W-1:0] hi_raw,
   input  logic [HI_W-1:0] hi_inc,
   output logic [HI_W-1:0] hi_out
);
   always_comb hi_out = carry ? hi_inc : hi_raw;
endmodule

// File: rtl/fetch_pc_incr.sv
module fetch_pc_incr #(
   parameter int unsigned PC_W        = 32,
   parameter int unsigned LO_W        = 3,
   parameter int unsigned BASE_BYTES  = 1,
   parameter int unsigned REGID_BYTES = 1,
   parameter int unsigned CONST_BYTES = 4,
   parameter bit          REG_OUT     = 1'b1,
   parameter fetch_pc_incr_pkg::inc_style_e INC_STYLE = fetch_pc_incr_pkg::INC_PREFIX
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] pc_i,
   input  logic            need_regid_i,
   input  logic            need_const_i,
   output logic [LO_W-1:0] ilen_o,
   output logic [PC_W-1:0] next_pc_o
);
   localparam int unsigned HI_W = PC_W - LO_W;

   if (LO_W < 1 || LO_W >= PC_W) begin : g_bad_split
      $error("fetch_pc_incr: LO_W must lie between 1 and PC_W-1");
   end

   logic [LO_W-1:0] len_w;
   logic [LO_W-1:0] lo_sum_w;
   logic            carry_w;
   logic [HI_W-1:0] hi_raw_w;
   logic [HI_W-1:0] hi_inc_w;
   logic [HI_W-1:0] hi_out_w;
   logic [PC_W-1:0] comb_next_w;

   assign hi_raw_w = pc_i[PC_W-1:LO_W];

   fetch_pc_incr_len #(
      .LEN_W(LO_W), .BASE_BYTES(BASE_BYTES),
      .REGID_BYTES(REGID_BYTES), .CONST_BYTES(CONST_BYTES)
   ) u_len (
      .has_regid(need_regid_i), .has_const(need_const_i), .len(len_w)
   );

   fetch_pc_incr_hi #(.HI_W(HI_W), .STYLE(INC_STYLE)) u_hi (
      .hi_raw(hi_raw_w), .hi_inc(hi_inc_w)
   );

   fetch_pc_incr_lo #(.LO_W(LO_W)) u_lo (
      .lo_raw(pc_i[LO_W-1:0]), .len(len_w), .lo_sum(lo_sum_w), .carry(carry_w)
   );

   fetch_pc_incr_sel #(.HI_W(HI_W)) u_sel (
      .carry(carry_w), .hi_raw(hi_raw_w), .hi_inc(hi_inc_w), .hi_out(hi_out_w)
   );

   assign comb_next_w = {hi_out_w, lo_sum_w};
   assign ilen_o      = len_w;

   if (REG_OUT) begin : g_reg
      logic [PC_W-1:0] next_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) next_q <= '0;
         else        next_q <= comb_next_w;
      end
      assign next_pc_o = next_q;
   end else begin : g_comb
      assign next_pc_o = comb_next_w;
   end

endmodule

// File: rtl/fetch_pc_incr_chk.sv
module fetch_pc_incr_chk #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned LO_W    = 3,
   parameter bit          REG_OUT = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] pc_i,
   input logic            need_regid_i,
   input logic            need_const_i,
   input logic [LO_W-1:0] ilen_o,
   input logic            carry_w,
   input logic [PC_W-1:0] comb_next_w,
   input logic [PC_W-1:0] next_pc_o
);
   localparam int unsigned HI_W = PC_W - LO_W;

   logic [PC_W-1:0] sum_ref;
   assign sum_ref = pc_i + {{HI_W{1'b0}}, ilen_o};

   // R1
   shortest_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!need_regid_i && !need_const_i) |-> ilen_o == LO_W'(1));
   // R1
   longest_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (need_regid_i && need_const_i) |-> ilen_o == LO_W'(6));
   // R2
   full_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      comb_next_w == sum_ref);
   // R4
   upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_w |-> comb_next_w[PC_W-1:LO_W] == pc_i[PC_W-1:LO_W]);
   // R5
   upper_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      carry_w |-> comb_next_w[PC_W-1:LO_W] == pc_i[PC_W-1:LO_W] + HI_W'(1));

   if (REG_OUT) begin : g_reg_chk
      // R7
      out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> next_pc_o == $past(sum_ref));
   end else begin : g_comb_chk
      // R7
      out_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
         next_pc_o == sum_ref);
   end

endmodule

bind fetch_pc_incr fetch_pc_incr_chk #(
   .PC_W(PC_W), .LO_W(LO_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pc_i(pc_i),
   .need_regid_i(need_regid_i), .need_const_i(need_const_i),
   .ilen_o(ilen_o), .carry_w(carry_w), .comb_next_w(comb_next_w),
   .next_pc_o(next_pc_o)
);

// File: tb/fetch_pc_incr_test.sv
module fetch_pc_incr_test;

   typedef struct packed {
      logic [31:0] pc;
      logic        r;
      logic        c;
   } vec_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc_i = '0;
   logic        need_regid_i = 1'b0;
   logic        need_const_i = 1'b0;
   logic [2:0]  ilen_o;
   logic [31:0] next_pc_o;

   int checks = 0;
   int errors = 0;
   vec_t pend[$];

   always #2 clk = ~clk;

   fetch_pc_incr uut (
      .clk(clk), .rst_n(rst_n), .pc_i(pc_i),
      .need_regid_i(need_regid_i), .need_const_i(need_const_i),
      .ilen_o(ilen_o), .next_pc_o(next_pc_o)
   );

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int unsigned len_of(input logic r, input logic c);
      return 1 + (r ? 1 : 0) + (c ? 4 : 0);
   endfunction

   task automatic verify_out();
      vec_t v;
      longint unsigned full;
      int unsigned lsum;
      if (pend.size() == 0) return;
      v    = pend.pop_front();
      full = (longint'(v.pc) + len_of(v.r, v.c)) & 64'hFFFF_FFFF;
      lsum = v.pc[2:0] + len_of(v.r, v.c);
      check("R2", next_pc_o, full[31:0]);
      check("R3", {29'd0, next_pc_o[2:0]}, lsum % 8);
      if (lsum < 8)
         check("R4", {3'd0, next_pc_o[31:3]}, {3'd0, v.pc[31:3]});
      else
         check("R5", {3'd0, next_pc_o[31:3]}, {3'd0, v.pc[31:3] + 29'd1});
      if (v.pc[31:3] == '1 && lsum >= 8)
         check("R6", {3'd0, next_pc_o[31:3]}, 32'd0);
   endtask

   task automatic step(input logic [31:0] pc, input logic r, input logic c);
      vec_t v;
      @(negedge clk);
      verify_out();
      pc_i = pc; need_regid_i = r; need_const_i = c;
      #1;
      check("R1", {29'd0, ilen_o}, len_of(r, c));
      v.pc = pc; v.r = r; v.c = c;
      pend.push_back(v);
   endtask

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R7 reset", next_pc_o, 32'd0);
      rst_n = 1'b1;

      // every low field against every length, random upper part
      for (int lo = 0; lo < 8; lo++)
         for (int f = 0; f < 4; f++)
            step({$urandom() & 32'hFFFF_FFF8} | 32'(lo), f[0], f[1]);

      // carry boundary cases, low bits 3..7
      for (int lo = 3; lo < 8; lo++)
         for (int f = 0; f < 4; f++)
            step(32'h0000_0FF8 | 32'(lo), f[0], f[1]);

      // wrap at the top of the address space
      for (int lo = 0; lo < 8; lo++)
         for (int f = 0; f < 4; f++)
            step(32'hFFFF_FFF8 | 32'(lo), f[0], f[1]);

      // long ripple through the upper field
      step(32'h7FFF_FFFF, 1'b0, 1'b0);
      step(32'h0FFF_FFFE, 1'b1, 1'b1);

      // back-to-back random traffic
      for (int i = 0; i < 2000; i++)
         step($urandom(), 1'($urandom()), 1'($urandom()));

      // mid-run reset clears the registered output
      @(negedge clk);
      verify_out();
      rst_n = 1'b0;
      @(negedge clk);
      check("R7 mid reset", next_pc_o, 32'd0);
      rst_n = 1'b1;
      step(32'h0000_0003, 1'b1, 1'b1);
      step(32'h0000_0010, 1'b0, 1'b0);
      @(negedge clk);
      verify_out();
      @(negedge clk);
      verify_out();

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule